// File: doc/BRIEF.md
# Load/Store Address Checker and Router

This block sits between an address translator and the memory system. It takes one physical load or store at a time, either a 32-bit word or a single byte. It decides whether the access is legal, and it sends the access either to a RAM port or to a memory-mapped device port. A word access with a misaligned address is refused. An address inside an inclusive device window goes to the device port. Any other address is bounded by the configured RAM size. Each access that is refused returns a load or store address-error flag instead of data.

For byte accesses to RAM, a parameter selects big-endian or little-endian lane numbering. In big-endian mode the low two address bits are inverted before they select the RAM byte lane. The device window is always compared against the address as received. Byte loads return the selected byte with zero extension to 32 bits.

Requests use a valid/ready handshake, and only one access is in flight. While a store is in progress, the block drives a write indication back to the translator.

Top module: `mem_access_router`

## Requirements
- R1: A word access (req_is_word=1) whose address has bit 1 or bit 0 set faults. A load raises rsp_err_load and a store raises rsp_err_store. This alignment check comes first, so it also applies inside the device window.
- R2: An access whose address A satisfies MMIO_LO <= A <= MMIO_HI (both ends included) drives dev_req and never ram_req, for words and for bytes.
- R3: The device window compare and dev_addr use the address exactly as received, with no endianness adjustment.
- R4: An access outside the device window whose address is >= RAM_BYTES faults. A load raises rsp_err_load and a store raises rsp_err_store.
- R5: For a RAM byte access, ram_addr[1:0] is the request's bits 1:0 XOR 2'b11 when BIG_ENDIAN=1, and unchanged when BIG_ENDIAN=0. Word accesses keep bits 1:0 at 00.
- R6: A load returns the full 32-bit word for words. For bytes it returns the selected byte zero-extended to 32 bits. The RAM byte is lane ram_addr[1:0] of ram_rdata, with lane k at bits 8k+7:8k. The device byte is dev_rdata[7:0].
- R7: xlat_write is high from the cycle after a store is accepted through its response cycle, and low in every other cycle.
- R8: req_ready is high only when no access is in flight. The memory or device request is driven in the cycle after acceptance, and rsp_valid is high for exactly the following cycle. RAM and device read data are taken one clock after their request.
- R9: A faulting access drives neither ram_req nor dev_req, and it returns rsp_rdata=0.
- R10: A RAM byte store drives ram_be one-hot on lane ram_addr[1:0] and puts the byte on all four lanes of ram_wdata. A word store drives ram_be=4'hF and leaves the data unchanged.
- R11: After reset, req_ready=1 and rsp_valid, ram_req, dev_req and xlat_write are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Physical address |
| req_is_word | input | 1 | 1 = word access, 0 = byte access |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 32 | Store data (byte in bits 7:0) |
| rsp_valid | output | 1 | Response cycle |
| rsp_rdata | output | 32 | Load data |
| rsp_err_load | output | 1 | Load address error |
| rsp_err_store | output | 1 | Store address error |
| xlat_write | output | 1 | Current access is a store |
| ram_req | output | 1 | RAM request |
| ram_we | output | 1 | RAM write |
| ram_addr | output | $clog2(RAM_BYTES) | RAM byte address |
| ram_be | output | 4 | RAM byte enables |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read word, one clock after request |
| dev_req | output | 1 | Device request |
| dev_we | output | 1 | Device write |
| dev_word | output | 1 | Device access is a word |
| dev_addr | output | 32 | Device address |
| dev_wdata | output | 32 | Device write data |
| dev_rdata | input | 32 | Device read data, one clock after request |

## Verification
The bench probes each end of the device window and the addresses just outside it, the last word and the last byte below the RAM size, and the first address at the RAM size. If the window compare were exclusive, or the ceiling compare used > instead of >=, these accesses would go to the wrong port or would fault when they should not. A misaligned word inside the window must fault. A design that checked the window before alignment would send it to the device instead. Byte loads and stores on all four lanes expose a missing or misplaced lane swap, sign extension instead of zero extension, and a wrong byte enable. Store/load mixes show whether the write indication stays high too long or too briefly.

// File: rtl/mem_access_router.sv
module mem_access_router #(
  parameter int unsigned RAM_BYTES  = 4096,
  parameter logic [31:0] MMIO_LO    = 32'h1F00_0000,
  parameter logic [31:0] MMIO_HI    = 32'h1F00_00FF,
  parameter bit          BIG_ENDIAN = 1'b1,
  localparam int unsigned RAM_AW    = $clog2(RAM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic              req_is_word,
  input  logic              req_is_store,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err_load,
  output logic              rsp_err_store,
  output logic              xlat_write,
  output logic              ram_req,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [3:0]        ram_be,
  output logic [31:0]       ram_wdata,
  input  logic [31:0]       ram_rdata,
  output logic              dev_req,
  output logic              dev_we,
  output logic              dev_word,
  output logic [31:0]       dev_addr,
  output logic [31:0]       dev_wdata,
  input  logic [31:0]       dev_rdata
);

  localparam logic [31:0] CEIL = 32'(RAM_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_RESP} st_t;

  st_t         st;
  logic [31:0] a_q, wd_q;
  logic        word_q, store_q, fault_q, mmio_q;

  logic misalign, in_win, over_ceil, accept;
  assign accept    = req_valid && req_ready;
  assign misalign  = req_is_word && (req_addr[1:0] != 2'b00);
  assign in_win    = (req_addr >= MMIO_LO) && (req_addr <= MMIO_HI);
  assign over_ceil = req_addr >= CEIL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      a_q     <= '0;
      wd_q    <= '0;
      word_q  <= 1'b0;
      store_q <= 1'b0;
      fault_q <= 1'b0;
      mmio_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st      <= S_ISSUE;
          a_q     <= req_addr;
          wd_q    <= req_wdata;
          word_q  <= req_is_word;
          store_q <= req_is_store;
          fault_q <= misalign || (!in_win && over_ceil);
          mmio_q  <= in_win && !misalign;
        end
        S_ISSUE: st <= S_RESP;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [1:0] lane;
  generate
    if (BIG_ENDIAN) begin : g_be
      assign lane = word_q ? 2'b00 : (a_q[1:0] ^ 2'b11);
    end else begin : g_le
      assign lane = word_q ? 2'b00 : a_q[1:0];
    end
  endgenerate

  logic issue_ok;
  assign issue_ok  = (st == S_ISSUE) && !fault_q;
  assign req_ready = (st == S_IDLE);
  assign xlat_write = store_q && (st != S_IDLE);

  assign ram_req   = issue_ok && !mmio_q;
  assign ram_we    = store_q;
  assign ram_addr  = {a_q[RAM_AW-1:2], lane};
  assign ram_be    = word_q ? 4'hF : (4'b0001 << lane);
  assign ram_wdata = word_q ? wd_q : {4{wd_q[7:0]}};

  assign dev_req   = issue_ok && mmio_q;
  assign dev_we    = store_q;
  assign dev_word  = word_q;
  assign dev_addr  = a_q;
  assign dev_wdata = wd_q;

  logic [31:0] load_val;
  always_comb begin
    if (mmio_q) load_val = word_q ? dev_rdata : {24'h0, dev_rdata[7:0]};
    else        load_val = word_q ? ram_rdata : {24'h0, ram_rdata[8*lane +: 8]};
  end

  assign rsp_valid     = (st == S_RESP);
  assign rsp_rdata     = (rsp_valid && !fault_q && !store_q) ? load_val : 32'h0;
  assign rsp_err_load  = rsp_valid && fault_q && !store_q;
  assign rsp_err_store = rsp_valid && fault_q && store_q;

  p_word_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_req && ram_be == 4'hF) |-> (ram_addr[1:0] == 2'b00));
  p_one_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_req && dev_req));
  p_err_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_err_load && rsp_err_store));
  p_store_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_is_store) |=> xlat_write);
  p_load_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_is_store) |=> !xlat_write);
  p_rsp_timing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##1 rsp_valid);
  p_rsp_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_fault_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_err_load || rsp_err_store) |-> $past(!ram_req && !dev_req));
  p_be_shape_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ram_req |-> (ram_be == 4'hF || $countones(ram_be) == 1));

endmodule

// File: tb/mem_access_router_tb.sv
module mem_access_router_tb_top;
  localparam int unsigned RB = 4096;
  localparam logic [31:0] LO = 32'h1F00_0000;
  localparam logic [31:0] HI = 32'h1F00_00FF;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 0, req_is_word = 0, req_is_store = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic req_ready, rsp_valid, rsp_err_load, rsp_err_store, xlat_write;
  logic [31:0] rsp_rdata;
  logic ram_req, ram_we, dev_req, dev_we, dev_word;
  logic [11:0] ram_addr;
  logic [3:0] ram_be;
  logic [31:0] ram_wdata, ram_rdata, dev_addr, dev_wdata, dev_rdata;

  mem_access_router #(.RAM_BYTES(RB), .MMIO_LO(LO), .MMIO_HI(HI), .BIG_ENDIAN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_is_word(req_is_word), .req_is_store(req_is_store),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err_load(rsp_err_load), .rsp_err_store(rsp_err_store), .xlat_write(xlat_write),
    .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr), .ram_be(ram_be),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .dev_req(dev_req), .dev_we(dev_we),
    .dev_word(dev_word), .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata));

  logic [31:0] mem [RB/4];
  logic [31:0] shadow [RB/4];

  always_ff @(posedge clk) begin
    if (ram_req) begin
      ram_rdata <= mem[ram_addr[11:2]];
      if (ram_we)
        for (int k = 0; k < 4; k++)
          if (ram_be[k]) mem[ram_addr[11:2]][8*k +: 8] <= ram_wdata[8*k +: 8];
    end
    if (dev_req) dev_rdata <= dev_addr ^ 32'hDEC0_0000;
  end

  int errors = 0, checks = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // 0 = RAM, 1 = device, 2 = misaligned fault, 3 = ceiling fault
  function automatic int classify(input logic [31:0] a, input bit w);
    if (w && a[1:0] != 2'b00) return 2;
    if (a >= LO && a <= HI) return 1;
    if (a >= RB) return 3;
    return 0;
  endfunction

  task automatic access(input logic [31:0] a, input bit w, input bit s, input logic [31:0] d);
    int cls;
    logic [1:0] ln;
    logic [31:0] exp, dv;
    cls = classify(a, w);
    ln  = w ? 2'b00 : (a[1:0] ^ 2'b11);
    @(negedge clk);
    chk(req_ready === 1'b1, "R8 ready when idle", {31'b0, req_ready}, 32'd1);
    req_valid = 1; req_addr = a; req_is_word = w; req_is_store = s; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready === 1'b0, "R8 busy not ready", {31'b0, req_ready}, 32'd0);
    chk(ram_req === (cls == 0), "R9 ram_req", {31'b0, ram_req}, {31'b0, cls == 0});
    chk(dev_req === (cls == 1), "R2 dev_req", {31'b0, dev_req}, {31'b0, cls == 1});
    chk(xlat_write === s, "R7 write flag issue", {31'b0, xlat_write}, {31'b0, s});
    chk(rsp_valid === 1'b0, "R8 no early rsp", {31'b0, rsp_valid}, 32'd0);
    if (cls == 0) begin
      chk(ram_addr === {a[11:2], ln}, "R5 ram byte address", {20'b0, ram_addr}, {20'b0, a[11:2], ln});
      if (s) begin
        chk(ram_be === (w ? 4'hF : (4'b0001 << ln)), "R10 byte enable", {28'b0, ram_be},
            {28'b0, (w ? 4'hF : (4'b0001 << ln))});
        chk(ram_wdata === (w ? d : {4{d[7:0]}}), "R10 write data", ram_wdata, (w ? d : {4{d[7:0]}}));
        if (w) shadow[a[11:2]] = d;
        else   shadow[a[11:2]][8*ln +: 8] = d[7:0];
      end
    end
    if (cls == 1) begin
      chk(dev_addr === a, "R3 device address unswapped", dev_addr, a);
      chk(dev_we === s && dev_word === w, "R2 device kind", {30'b0, dev_we, dev_word}, {30'b0, s, w});
    end
    @(negedge clk);
    chk(rsp_valid === 1'b1, "R8 rsp cycle", {31'b0, rsp_valid}, 32'd1);
    chk(rsp_err_load === (cls >= 2 && !s), cls == 2 ? "R1 load error" : "R4 load error",
        {31'b0, rsp_err_load}, {31'b0, cls >= 2 && !s});
    chk(rsp_err_store === (cls >= 2 && s), cls == 2 ? "R1 store error" : "R4 store error",
        {31'b0, rsp_err_store}, {31'b0, cls >= 2 && s});
    chk(xlat_write === s, "R7 write flag rsp", {31'b0, xlat_write}, {31'b0, s});
    exp = 32'h0;
    if (!s && cls == 0) exp = w ? shadow[a[11:2]] : {24'h0, shadow[a[11:2]][8*ln +: 8]};
    if (!s && cls == 1) begin
      dv  = a ^ 32'hDEC0_0000;
      exp = w ? dv : {24'h0, dv[7:0]};
    end
    chk(rsp_rdata === exp, cls >= 2 ? "R9 fault data" : "R6 load data", rsp_rdata, exp);
    @(negedge clk);
    chk(xlat_write === 1'b0 && rsp_valid === 1'b0, "R7 flag cleared",
        {30'b0, xlat_write, rsp_valid}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < RB/4; i++) begin
      mem[i]    = (i * 32'h0101_0101) ^ 32'hF08C_3A65;
      shadow[i] = (i * 32'h0101_0101) ^ 32'hF08C_3A65;
    end
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0 && ram_req === 1'b0 && dev_req === 1'b0
        && xlat_write === 1'b0, "R11 reset state",
        {27'b0, req_ready, rsp_valid, ram_req, dev_req, xlat_write}, 32'h10);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R11 ready after reset", {31'b0, req_ready}, 32'd1);

    access(32'h0000_0101, 1, 0, 0);            // R1 misaligned load
    access(32'h0000_0102, 1, 1, 32'h1);        // R1 misaligned store
    access(LO + 32'd2, 1, 0, 0);               // R1 wins inside window
    access(32'h0000_0040, 1, 1, 32'hCAFE_F00D);
    for (int b = 0; b < 4; b++) access(32'h0000_0040 + b, 0, 0, 0);   // R5 R6 lanes
    for (int b = 0; b < 4; b++) access(32'h0000_0080 + b, 0, 1, 32'hA0 + b); // R10
    access(32'h0000_0080, 1, 0, 0);
    access(32'h0000_0044, 1, 1, 32'h8081_8283); // high bytes for zero extension
    access(32'h0000_0047, 0, 0, 0);
    access(RB - 4, 1, 0, 0);                   // last word
    access(RB - 1, 0, 0, 0);                   // last byte
    access(RB, 1, 0, 0);                       // R4 ceiling load
    access(RB, 0, 1, 32'h55);                  // R4 ceiling store
    access(LO, 1, 0, 0);                       // R2 low edge
    access(HI, 0, 0, 0);                       // R2 high edge byte
    access(HI - 3, 1, 1, 32'h1234_5678);
    access(LO + 32'd1, 0, 0, 0);               // R3 byte in window
    access(HI + 1, 0, 0, 0);                   // R4 just above window
    access(LO - 1, 0, 1, 32'h77);              // R4 just below window

    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      bit w, s;
      w = $urandom % 2;
      s = $urandom % 2;
      case ($urandom % 4)
        0: a = $urandom % RB;
        1: a = LO + ($urandom % 256);
        2: a = RB - 8 + ($urandom % 16);
        default: a = $urandom;
      endcase
      if (w && ($urandom % 4 != 0)) a[1:0] = 2'b00;
      access(a, w, s, $urandom);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule